// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit counter behind a large clock prescaler. It has two personalities. In interval-timer mode, each overflow reloads the counter from a reload register, counting resumes at once, and a one-cycle interrupt request is raised if the interrupt enable input is high. In watchdog mode, software must refresh the counter before it overflows. If it does not, the block drives a system reset pulse that is stretched to a fixed minimum length.

A small register bus carries three registers: control, reload and a feed port. In watchdog mode, control writes are locked. A write is accepted only when the two-write feed sequence immediately precedes it. The mode bit can be set by software, but only the power-on reset clears it. A force-on bit keeps the watchdog counting whatever the run bit says, until the watchdog overflows.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the control register (address 0) reads 0x00 and the reload register (address 1) reads 0x00. The counter (read at address 2) is 0, and `irq_pulse` and `sys_rst` are low. Read data appears one clock after the address is presented.
- R2: The control bits are: bit 0 run, bit 1 refresh, bit 2 status, bit 3 mode (1 = watchdog), bit 6 force-on. After a refresh, with the counter running, the first overflow comes (255 − reload) × PRESCALE clocks after the write. A reload of 255 overflows after PRESCALE clocks.
- R3: In timer mode, an overflow reloads the counter from the reload register. Later overflows then follow every (255 − reload) × PRESCALE clocks with no software action.
- R4: `irq_pulse` is high for exactly one clock per overflow, and only when the block is in timer mode with `irq_en` high. It stays low when `irq_en` is low and in watchdog mode.
- R5: The status bit is set by any overflow and stays set until it is cleared. Writing 1 to status in an accepted control write clears it. In timer mode no feed is needed for that write.
- R6: With the run bit clear (and force-on not in effect), the counter holds its value.
- R7: The mode bit is set by an accepted control write with bit 3 high. Writing 0 to it has no effect, and only power-on reset clears it.
- R8: In watchdog mode, a control write is accepted only when the previous two bus writes were 0xAA and then 0x55 to the feed address (2). Any other write in between breaks the sequence. One sequence unlocks one control write.
- R9: A watchdog-mode overflow drives `sys_rst` high for exactly RST_LEN (default 196) consecutive clocks. Overflows during that pulse neither extend nor restart it. An overflow after the pulse starts a new one.
- R10: In watchdog mode, the force-on bit keeps the counter running with the run bit clear. A write cannot clear force-on; a watchdog overflow clears it.
- R11: The reload register can be written in either mode without a feed sequence.
- R12: The refresh bit reads as 0. An accepted write with refresh set loads the counter from the reload register and restarts the prescaler, so the next overflow is timed from that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 feed (write) / counter (read) |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_en | input | 1 | Interrupt enable for timer-mode overflows |
| irq_pulse | output | 1 | One-cycle interrupt request |
| sys_rst | output | 1 | Stretched system reset from a watchdog overflow |

## Verification
The timer is measured with a short reload (250), a reload of 255, and a refresh issued in the middle of a prescaler period. This shows whether timing starts at the write, whether the prescaler is cleared, and whether the overflow comes at 254 rather than 255. Several overflows in a row with no software action confirm the automatic reload. Runs with `irq_en` low, and in watchdog mode, show that the interrupt depends on both enable and mode.

The lock is tried with:
- no feed at all;
- a correct feed;
- a feed broken by a reload write;
- two control writes after one feed.

Together these separate a lock that opens once from one that stays open or ignores the order of writes. A reload of 254, giving an overflow every few clocks during the reset pulse, shows whether those overflows stretch the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_FEED   = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_RUN     = 0;
  localparam int unsigned BIT_REFRESH = 1;
  localparam int unsigned BIT_STATUS  = 2;
  localparam int unsigned BIT_MODE    = 3;
  localparam int unsigned BIT_FORCE   = 6;

  localparam logic [CNT_W-1:0] FEED_FIRST  = 8'hAA;
  localparam logic [CNT_W-1:0] FEED_SECOND = 8'h55;
endpackage

// File: rtl/wdog_feed_lock.sv
module wdog_feed_lock
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic             unlocked
);
  logic armed_q;
  logic unlock_q;
  logic is_feed;

  assign is_feed  = (addr == ADDR_FEED);
  assign unlocked = unlock_q;

  // Every write re-evaluates both flags, so any intervening write breaks
  // the sequence and the unlock lasts for exactly one following write.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      unlock_q <= 1'b0;
    end else if (we) begin
      armed_q  <= is_feed && (wdata == FEED_FIRST);
      unlock_q <= armed_q && is_feed && (wdata == FEED_SECOND);
    end
  end

  // R8: the unlock is consumed by the next write, whatever it is
  assert_single_unlock_R8: assert property (@(posedge clk) disable iff (rst)
    (unlock_q && we) |=> !unlock_q);
endmodule

// File: rtl/wdog_tick_count.sv
module wdog_tick_count
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE = 344064
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'((2 ** CNT_W) - 2);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] pre_q;
      assign tick = run && (pre_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (rst || load || tick) pre_q <= '0;
        else if (run)            pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate

  // The step that would reach the all-ones value counts as the overflow.
  assign ovf   = tick && !load && (cnt_q >= LAST_STEP);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= reload;
    else if (ovf)   cnt_q <= reload;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // R3: an overflow leaves the counter at the reload value
  assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (count == $past(reload)));
  // R6: with no run and no load the counter holds
  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int unsigned RST_LEN = 196
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic rst_out
);
  localparam int unsigned LW = $clog2(RST_LEN + 1);

  logic [LW-1:0] left_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      out_q  <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      out_q  <= (left_q != LW'(1));
    end else if (trigger) begin
      left_q <= LW'(RST_LEN);
      out_q  <= 1'b1;
    end
  end

  assign rst_out = out_q;

  // R9: the pulse is never a single clock
  assert_min_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |=> rst_out);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE = 344064,
  parameter int unsigned RST_LEN  = 196
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en,
  output logic       irq_pulse,
  output logic       sys_rst
);
  logic             mode_q, run_q, force_q, status_q, irq_q;
  logic [CNT_W-1:0] reload_q, rdata_q, rd_next, count;
  logic             unlocked, ctrl_wr, refresh, ovf, cnt_run;

  wdog_feed_lock u_lock (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .unlocked(unlocked)
  );

  assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL) && (!mode_q || unlocked);
  assign refresh = ctrl_wr && bus_wdata[BIT_REFRESH];
  assign cnt_run = run_q || (mode_q && force_q);

  wdog_tick_count #(.PRESCALE(PRESCALE)) u_count (
    .clk(clk), .rst(rst), .run(cnt_run), .load(refresh),
    .reload(reload_q), .count(count), .ovf(ovf)
  );

  wdog_rst_stretch #(.RST_LEN(RST_LEN)) u_stretch (
    .clk(clk), .rst(rst), .trigger(ovf && mode_q), .rst_out(sys_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      run_q    <= 1'b0;
      force_q  <= 1'b0;
      status_q <= 1'b0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= ovf && !mode_q && irq_en;
      if (bus_we && (bus_addr == ADDR_RELOAD)) reload_q <= bus_wdata;
      if (ctrl_wr) begin
        run_q <= bus_wdata[BIT_RUN];
        if (bus_wdata[BIT_MODE])   mode_q   <= 1'b1;
        if (bus_wdata[BIT_STATUS]) status_q <= 1'b0;
      end
      if (ovf && mode_q)                          force_q <= 1'b0;
      else if (ctrl_wr && bus_wdata[BIT_FORCE])   force_q <= 1'b1;
      if (ovf) status_q <= 1'b1;
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        rd_next[BIT_RUN]    = run_q;
        rd_next[BIT_STATUS] = status_q;
        rd_next[BIT_MODE]   = mode_q;
        rd_next[BIT_FORCE]  = force_q;
      end
      ADDR_RELOAD: rd_next = reload_q;
      ADDR_FEED:   rd_next = count;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign irq_pulse = irq_q;

  // R4: single-cycle request, never in watchdog mode
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  assert_irq_timer_only_R4: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !$past(mode_q));
  // R7: mode is sticky once set
  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> mode_q);
  // R5: status only rises on an overflow
  assert_status_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(ovf));
  // R8: a watchdog-mode control write without unlock leaves run unchanged
  assert_locked_write_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q && bus_we && (bus_addr == ADDR_CTRL) && !unlocked) |=> $stable(run_q));
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam int unsigned PS  = 4;
  localparam int unsigned RLN = 196;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_en = 1'b0;
  logic       irq_pulse;
  logic       sys_rst;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  wdog_timer #(.PRESCALE(PS), .RST_LEN(RLN)) u_wdog_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en),
    .irq_pulse(irq_pulse), .sys_rst(sys_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk); rst = 1'b1; bus_we = 1'b0; irq_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic feed();
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55);
  endtask

  // Counts rising edges until the chosen output is seen high; -1 on timeout.
  task automatic wait_hi(input int which, input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if ((which == 0 && irq_pulse) || (which == 1 && sys_rst)) begin
        n = i; return;
      end
    end
    n = -1;
  endtask

  task automatic t_reset();
    int v;
    por();
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 reload", v, 0);
    rd(2'd2, v); chk("R1 counter", v, 0);
    chk("R1 irq", irq_pulse, 0);
    chk("R1 sys_rst", sys_rst, 0);
  endtask

  task automatic t_timer();
    int n, v;
    por(); irq_en = 1'b1;
    wr(2'd1, 8'd250);
    wr(2'd0, 8'h03);
    wait_hi(0, 100, n); chk("R2 first period", n, 5 * PS);
    @(posedge clk); @(negedge clk); chk("R4 one-cycle irq", irq_pulse, 0);
    wait_hi(0, 100, n); chk("R3 auto reload period", n, 5 * PS - 1);
    wait_hi(0, 100, n); chk("R3 third period", n, 5 * PS);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R5 status set", (v >> 2) & 1, 1);
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R5 status cleared no feed", (v >> 2) & 1, 0);
    rd(2'd2, v); repeat (10) @(negedge clk);
    begin int w; rd(2'd2, w); chk("R6 counter holds", w, v); end
  endtask

  task automatic t_noirq_and_max();
    int n, v;
    por(); irq_en = 1'b0;
    wr(2'd1, 8'd255);
    wr(2'd0, 8'h03);
    wait_hi(0, 30, n); chk("R4 no irq when disabled", n, -1);
    rd(2'd0, v); chk("R5 status set without irq", (v >> 2) & 1, 1);
    irq_en = 1'b1;
    wr(2'd0, 8'h03);
    wait_hi(0, 30, n); chk("R2 reload 255 period", n, PS);
  endtask

  task automatic t_refresh();
    int n, v;
    por(); irq_en = 1'b1;
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h02);
    rd(2'd2, v); chk("R12 refresh loads counter", v, 200);
    rd(2'd0, v); chk("R12 refresh reads 0", v, 0);
    wr(2'd1, 8'd250);
    wr(2'd0, 8'h03);
    repeat (7) @(negedge clk);
    wr(2'd0, 8'h03);
    wait_hi(0, 100, n); chk("R12 timing restarts at refresh", n, 5 * PS);
  endtask

  task automatic t_watchdog();
    int n, v;
    por(); irq_en = 1'b1;
    wr(2'd1, 8'd250);
    wr(2'd0, 8'h08);
    rd(2'd0, v); chk("R7 mode set", v, 8'h08);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R8 write without feed ignored", v, 8'h08);
    wr(2'd2, 8'hAA); wr(2'd1, 8'd250); wr(2'd2, 8'h55); wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R8 broken feed ignored", v, 8'h08);
    wr(2'd1, 8'd252);
    rd(2'd1, v); chk("R11 reload write in watchdog", v, 252);
    wr(2'd1, 8'd250);
    feed(); wr(2'd0, 8'h0B);
    wait_hi(1, 100, n); chk("R9 reset timing", n, 5 * PS);
    chk("R4 no irq in watchdog", irq_pulse, 0);
    feed(); wr(2'd0, 8'h08); wr(2'd0, 8'h09);
    rd(2'd0, v); chk("R8 one write per feed", v & 1, 0);
    wait_hi(0, 300, n); chk("R4 no irq in watchdog run", n, -1);
    feed(); wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R7 mode not cleared", (v >> 3) & 1, 1);
    wr(2'd0, 8'h0C);
    rd(2'd0, v); chk("R5 clear needs feed", (v >> 2) & 1, 1);
    feed(); wr(2'd0, 8'h0C);
    rd(2'd0, v); chk("R5 clear after feed", (v >> 2) & 1, 0);
  endtask

  task automatic t_stretch();
    int n, len;
    por();
    wr(2'd1, 8'd254);
    wr(2'd0, 8'h08);
    feed(); wr(2'd0, 8'h0B);
    wait_hi(1, 50, n); chk("R9 short reload fires", n, PS);
    len = 1;
    while (sys_rst && len < 1000) begin @(negedge clk); if (sys_rst) len++; end
    chk("R9 pulse length", len, RLN);
    wait_hi(1, 20, n); chk("R9 retrigger after pulse", n > 0, 1);
    feed(); wr(2'd0, 8'h08);
  endtask

  task automatic t_force();
    int n, v, w;
    por();
    wr(2'd1, 8'd250);
    wr(2'd0, 8'h08);
    feed(); wr(2'd0, 8'h4A);
    rd(2'd0, v); chk("R10 force set, run clear", v, 8'h48);
    wr(2'd0, 8'h08);
    rd(2'd0, v); chk("R10 force not cleared by write", (v >> 6) & 1, 1);
    wait_hi(1, 100, n); chk("R10 forced overflow", n > 0, 1);
    rd(2'd0, v); chk("R10 force cleared by overflow", (v >> 6) & 1, 0);
    rd(2'd2, v); repeat (12) @(negedge clk); rd(2'd2, w);
    chk("R6 stopped after force", w, v);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_timer();
    t_noirq_and_max();
    t_refresh();
    t_watchdog();
    t_stretch();
    t_force();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule